// File: doc/BRIEF.md
# Hash Engine Mode and Length Sequencer

This block is the control sequencer of a block-based hash accelerator for MD5, SHA-1, SHA-224 and SHA-256. A simple register write port loads three registers: a mode register, a byte-length register and a digest byte-count register. Writing the length while the block is idle starts an operation. The sequencer then decides the order of work. It can run an HMAC key-processing pass first. It then fetches each full 64-byte input block and hands it to the compression core. It can close the hash with one padded final pass and finish with an HMAC outer pass. Every pass is a one-cycle start pulse to the core, which answers with a done pulse.

The sequencer keeps count of the bytes still to be consumed and of the running digest byte count. The one-shot mode bits clear themselves at the points where their work is finished, so software can read back what remains pending. The compression function, the padding datapath and the data mover are outside this block and appear only as handshakes.

Top module: `hash_seq_ctrl`

## Requirements
- R1: The mode register sits at select 0. Bit 7 requests the outer pass, bit 5 requests key processing, bit 4 requests closing with padding, bit 3 requests initial constants, and bits [2:1] pick the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256). `mode_q` reads back these bits with bits 6 and 0 at zero, and `core_algo` follows bits [2:1]. After reset, all outputs and registers are zero.
- R2: A write to select 1 (length) while idle starts an operation. For each full 64 bytes of remaining length, one block fetch (`blk_req` held until `blk_ack`) precedes one compression pass.
- R3: A length with nonzero bits [5:0] while close is 0 sets `len_error`. The flag stays set until reset. That write starts nothing, fetches nothing and loads no length.
- R4: A write to select 2 (digest count) stores the value with bits [5:0] forced to zero.
- R5: A start with the constants bit set, and the key bit clear, forces the digest count to 0. The constants bit clears when the first block or final pass completes, and it stays set if no such pass runs.
- R6: A start with the key bit set forces the digest count to 64 and runs a key pass before any other pass. The key bit clears when that pass completes.
- R7: Each completed full block adds 64 to the digest count and removes 64 from the remaining length, saturating at 0. A completed final pass adds the remaining bytes to the digest count and sets the remaining length to 0.
- R8: With close set, exactly one final pass follows the full blocks. It is preceded by a fetch only when a partial block of nonzero length remains. Close clears when that pass completes.
- R9: With the outer bit set, one outer pass runs after all inner work, and the outer bit clears when it completes.
- R10: When no work remains, `op_done` pulses for one cycle, `busy` falls and the remaining length is 0.
- R11: Writes to any register while `busy` is high are ignored.
- R12: `core_start` is a one-cycle pulse and is never high together with `blk_req`. `core_kind` is 0 for a block pass, 1 for a key pass, 2 for a final pass and 3 for an outer pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 mode, 1 length, 2 digest count |
| reg_wr_data | input | DW | Write data |
| blk_req | output | 1 | Request for the next input block |
| blk_ack | input | 1 | Input block delivered |
| core_start | output | 1 | One-cycle start pulse to the compression core |
| core_kind | output | 2 | Kind of pass being started |
| core_algo | output | 2 | Selected algorithm |
| core_init_const | output | 1 | Initial-constants request still pending |
| core_done | input | 1 | Core finished the current pass |
| remaining_len | output | DW | Bytes still to be consumed |
| digest_count | output | DW | Running digest byte count |
| mode_q | output | 8 | Mode register readback |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| len_error | output | 1 | Sticky misaligned-length error |

## Verification
The bench builds the block with its default 32-bit registers and 64-byte blocks. It sweeps all four algorithms against all sixteen combinations of the key, constants, close and outer bits, using lengths of 0, 5, 64, 100, 128, 191 and 256 bytes. This reaches every ordering of key, block, final and outer passes. It also reaches the empty-length case where the constants bit must survive, partial final blocks with and without a fetch, and every misaligned-length error. The core and fetch latencies vary from one operation to the next, and one run writes every register while busy.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  localparam int MB_OUTER = 7;
  localparam int MB_KEY   = 5;
  localparam int MB_CLOSE = 4;
  localparam int MB_CONST = 3;
  localparam int MB_ALGO  = 1;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  typedef enum logic [1:0] {
    JOB_BLOCK = 2'd0,
    JOB_KEY   = 2'd1,
    JOB_FINAL = 2'd2,
    JOB_OUTER = 2'd3
  } job_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DISPATCH, ST_KEY, ST_FETCH, ST_BLOCK, ST_FFETCH, ST_FINAL, ST_OUTER
  } st_e;

  typedef struct packed {
    logic       outer;
    logic       key;
    logic       close;
    logic       init_const;
    logic [1:0] algo;
  } mode_t;
endpackage

// File: rtl/hseq_mode_reg.sv
module hseq_mode_reg
  import hseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wr_data,
  input  logic       clr_key,
  input  logic       clr_const,
  input  logic       clr_close,
  input  logic       clr_outer,
  output mode_t      mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
    end else if (wr) begin
      mode.outer      <= wr_data[MB_OUTER];
      mode.key        <= wr_data[MB_KEY];
      mode.close      <= wr_data[MB_CLOSE];
      mode.init_const <= wr_data[MB_CONST];
      mode.algo       <= wr_data[MB_ALGO +: 2];
    end else begin
      if (clr_key)   mode.key        <= 1'b0;
      if (clr_const) mode.init_const <= 1'b0;
      if (clr_close) mode.close      <= 1'b0;
      if (clr_outer) mode.outer      <= 1'b0;
    end
  end
endmodule

// File: rtl/hseq_counters.sv
module hseq_counters #(
  parameter int DW  = 32,
  parameter int BLK = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_len,
  input  logic          ld_cnt,
  input  logic [DW-1:0] wr_data,
  input  logic          force_zero,
  input  logic          force_blk,
  input  logic          blk_done,
  input  logic          fin_done,
  output logic [DW-1:0] rem,
  output logic [DW-1:0] cnt,
  output logic          rem_full,
  output logic          rem_nz
);
  localparam int          BLG   = $clog2(BLK);
  localparam logic [DW-1:0] BLK_W = DW'(BLK);

  logic [DW-1:0] cnt_masked;

  generate
    if (BLG > 0) begin : g_mask
      assign cnt_masked = {wr_data[DW-1:BLG], {BLG{1'b0}}};
    end else begin : g_nomask
      assign cnt_masked = wr_data;
    end
  endgenerate

  assign rem_full = (rem >= BLK_W);
  assign rem_nz   = (rem != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (ld_len) begin
      rem <= wr_data;
    end else if (fin_done) begin
      rem <= '0;
    end else if (blk_done) begin
      rem <= rem_full ? rem - BLK_W : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_cnt) begin
      cnt <= cnt_masked;
    end else if (force_blk) begin
      cnt <= BLK_W;
    end else if (force_zero) begin
      cnt <= '0;
    end else if (blk_done) begin
      cnt <= cnt + BLK_W;
    end else if (fin_done) begin
      cnt <= cnt + rem;
    end
  end
endmodule

// File: rtl/hseq_fsm.sv
module hseq_fsm
  import hseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  mode_t mode,
  input  logic  rem_full,
  input  logic  rem_nz,
  input  logic  blk_ack,
  input  logic  core_done,
  output logic  blk_req,
  output logic  core_start,
  output job_e  core_kind,
  output logic  op_done,
  output logic  busy,
  output logic  clr_key,
  output logic  clr_const,
  output logic  clr_close,
  output logic  clr_outer,
  output logic  blk_done,
  output logic  fin_done
);
  st_e st;

  assign busy      = (st != ST_IDLE);
  assign clr_key   = (st == ST_KEY) && core_done;
  assign blk_done  = (st == ST_BLOCK) && core_done;
  assign fin_done  = (st == ST_FINAL) && core_done;
  assign clr_outer = (st == ST_OUTER) && core_done;
  assign clr_close = fin_done;
  assign clr_const = blk_done || fin_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      blk_req    <= 1'b0;
      core_start <= 1'b0;
      core_kind  <= JOB_BLOCK;
      op_done    <= 1'b0;
    end else begin
      core_start <= 1'b0;
      op_done    <= 1'b0;
      case (st)
        ST_IDLE: if (start) st <= ST_DISPATCH;
        ST_DISPATCH: begin
          if (mode.key) begin
            core_start <= 1'b1;
            core_kind  <= JOB_KEY;
            st         <= ST_KEY;
          end else if (rem_full) begin
            blk_req <= 1'b1;
            st      <= ST_FETCH;
          end else if (mode.close) begin
            if (rem_nz) begin
              blk_req <= 1'b1;
              st      <= ST_FFETCH;
            end else begin
              core_start <= 1'b1;
              core_kind  <= JOB_FINAL;
              st         <= ST_FINAL;
            end
          end else if (mode.outer) begin
            core_start <= 1'b1;
            core_kind  <= JOB_OUTER;
            st         <= ST_OUTER;
          end else begin
            op_done <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        ST_FETCH: if (blk_ack) begin
          blk_req    <= 1'b0;
          core_start <= 1'b1;
          core_kind  <= JOB_BLOCK;
          st         <= ST_BLOCK;
        end
        ST_FFETCH: if (blk_ack) begin
          blk_req    <= 1'b0;
          core_start <= 1'b1;
          core_kind  <= JOB_FINAL;
          st         <= ST_FINAL;
        end
        ST_KEY, ST_BLOCK, ST_FINAL, ST_OUTER: if (core_done) st <= ST_DISPATCH;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hash_seq_ctrl.sv
module hash_seq_ctrl
  import hseq_pkg::*;
#(
  parameter int DW  = 32,
  parameter int BLK = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_wr_sel,
  input  logic [DW-1:0] reg_wr_data,
  output logic          blk_req,
  input  logic          blk_ack,
  output logic          core_start,
  output logic [1:0]    core_kind,
  output logic [1:0]    core_algo,
  output logic          core_init_const,
  input  logic          core_done,
  output logic [DW-1:0] remaining_len,
  output logic [DW-1:0] digest_count,
  output logic [7:0]    mode_q,
  output logic          busy,
  output logic          op_done,
  output logic          len_error
);
  localparam int BLG = $clog2(BLK);

  mode_t mode;
  job_e  kind;
  logic  wr_mode, len_wr, ld_cnt, misaligned, start;
  logic  clr_key, clr_const, clr_close, clr_outer, blk_done, fin_done;
  logic  rem_full, rem_nz;

  assign wr_mode    = reg_wr_en && !busy && (reg_wr_sel == SEL_MODE);
  assign len_wr     = reg_wr_en && !busy && (reg_wr_sel == SEL_LEN);
  assign ld_cnt     = reg_wr_en && !busy && (reg_wr_sel == SEL_CNT);
  assign misaligned = !mode.close && (reg_wr_data[BLG-1:0] != '0);
  assign start      = len_wr && !misaligned;

  always_ff @(posedge clk) begin
    if (rst)                       len_error <= 1'b0;
    else if (len_wr && misaligned) len_error <= 1'b1;
  end

  hseq_mode_reg u_mode (
    .clk(clk), .rst(rst), .wr(wr_mode), .wr_data(reg_wr_data[7:0]),
    .clr_key(clr_key), .clr_const(clr_const), .clr_close(clr_close),
    .clr_outer(clr_outer), .mode(mode)
  );

  hseq_counters #(.DW(DW), .BLK(BLK)) u_cnt (
    .clk(clk), .rst(rst), .ld_len(start), .ld_cnt(ld_cnt), .wr_data(reg_wr_data),
    .force_zero(start && mode.init_const && !mode.key),
    .force_blk(start && mode.key),
    .blk_done(blk_done), .fin_done(fin_done),
    .rem(remaining_len), .cnt(digest_count), .rem_full(rem_full), .rem_nz(rem_nz)
  );

  hseq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .rem_full(rem_full),
    .rem_nz(rem_nz), .blk_ack(blk_ack), .core_done(core_done),
    .blk_req(blk_req), .core_start(core_start), .core_kind(kind),
    .op_done(op_done), .busy(busy), .clr_key(clr_key), .clr_const(clr_const),
    .clr_close(clr_close), .clr_outer(clr_outer), .blk_done(blk_done),
    .fin_done(fin_done)
  );

  assign core_kind       = kind;
  assign core_algo       = mode.algo;
  assign core_init_const = mode.init_const;
  assign mode_q = {mode.outer, 1'b0, mode.key, mode.close, mode.init_const, mode.algo, 1'b0};
endmodule

// File: rtl/hseq_checker.sv
module hseq_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          core_start,
  input logic [1:0]    core_kind,
  input logic          core_done,
  input logic          blk_req,
  input logic [DW-1:0] remaining_len,
  input logic [DW-1:0] digest_count,
  input logic          op_done,
  input logic          len_error
);
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  assert_no_start_with_fetch_R12: assert property (@(posedge clk) disable iff (rst)
    !(core_start && blk_req));

  assert_rem_nonincreasing_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && busy && $past(busy)) |-> (remaining_len <= $past(remaining_len)));

  assert_block_adds_count_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && core_done && !blk_req && core_kind == 2'd0) |=>
      (digest_count == $past(digest_count) + DW'(64)));

  assert_done_empty_R10: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (remaining_len == '0 && !busy));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

  assert_error_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(len_error)) |-> len_error);
endmodule

bind hash_seq_ctrl hseq_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .core_start(core_start), .core_kind(core_kind),
  .core_done(core_done), .blk_req(blk_req), .remaining_len(remaining_len),
  .digest_count(digest_count), .op_done(op_done), .len_error(len_error)
);

// File: tb/sim_hash_seq_ctrl.sv
module sim_hash_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_wr_sel = 2'd0;
  logic [DW-1:0] reg_wr_data = '0;
  logic          blk_req, blk_ack, core_start, core_init_const, core_done;
  logic [1:0]    core_kind, core_algo;
  logic [DW-1:0] remaining_len, digest_count;
  logic [7:0]    mode_q;
  logic          busy, op_done, len_error;

  int n_checks = 0, n_fail = 0;
  int n_starts = 0, n_fetch = 0, algo_bad = 0;
  int core_lat = 1, ack_lat = 1;
  int core_pend = 0, ack_pend = 0;
  bit ack_wait = 0;
  logic [1:0] exp_algo = 2'd0;
  logic [1:0] kinds [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_seq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .blk_req(blk_req), .blk_ack(blk_ack),
    .core_start(core_start), .core_kind(core_kind), .core_algo(core_algo),
    .core_init_const(core_init_const), .core_done(core_done),
    .remaining_len(remaining_len), .digest_count(digest_count), .mode_q(mode_q),
    .busy(busy), .op_done(op_done), .len_error(len_error)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stub core and stub data mover
  initial begin
    core_done = 1'b0;
    blk_ack   = 1'b0;
    forever begin
      @(negedge clk);
      core_done = 1'b0;
      blk_ack   = 1'b0;
      if (rst) begin
        core_pend = 0;
        ack_wait  = 0;
      end else begin
        if (core_start) begin
          kinds[n_starts] = core_kind;
          if (n_starts < 63) n_starts++;
          if (core_algo != exp_algo) algo_bad++;
          core_pend = core_lat;
        end else if (core_pend > 0) begin
          core_pend--;
          if (core_pend == 0) core_done = 1'b1;
        end
        if (ack_wait) begin
          ack_pend--;
          if (ack_pend == 0) begin
            blk_ack  = 1'b1;
            ack_wait = 0;
          end
        end else if (blk_req) begin
          ack_wait = 1;
          ack_pend = ack_lat;
          n_fetch++;
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] algo, input bit key, input bit cst,
                        input bit cls, input bit outr, input int len,
                        input logic [DW-1:0] init, input bit disturb);
    logic [7:0]    mode;
    logic [DW-1:0] base, exp_cnt;
    logic [7:0]    exp_mode;
    int blocks, exp_fetch, exp_starts, idx, guard;
    bit err_case;
    mode = {outr, 1'b0, key, cls, cst, algo, 1'b0};
    exp_algo = algo;
    n_starts = 0; n_fetch = 0; algo_bad = 0;
    wr(2'd2, init);
    check(digest_count == (init & ~32'h3F), "R4 count write low bits", digest_count, init & ~32'h3F);
    wr(2'd0, mode);
    check(mode_q == mode, "R1 mode readback", mode_q, mode);
    err_case = !cls && (len % 64 != 0);
    wr(2'd1, DW'(len));
    if (err_case) begin
      repeat (4) @(negedge clk);
      check(len_error == 1'b1, "R3 misaligned error", len_error, 1);
      check(!busy && n_fetch == 0 && n_starts == 0, "R3 nothing started",
            {busy, 8'(n_fetch), 8'(n_starts)}, 0);
      check(remaining_len == '0, "R3 length not loaded", remaining_len, 0);
      do_reset();
      return;
    end
    if (disturb) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R11 busy during op", busy, 1);
      wr(2'd0, 8'hFE);
      wr(2'd1, 32'd7);
      wr(2'd2, 32'hFFFF_FFC0);
    end
    guard = 0;
    while (!op_done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    blocks     = len / 64;
    exp_fetch  = blocks + ((cls && (len % 64) != 0) ? 1 : 0);
    exp_starts = (key ? 1 : 0) + blocks + (cls ? 1 : 0) + (outr ? 1 : 0);
    base       = key ? 32'd64 : (cst ? 32'd0 : (init & ~32'h3F));
    exp_cnt    = base + DW'(len);
    exp_mode   = {6'b0, algo, 1'b0} | ((cst && blocks == 0 && !cls) ? 8'h08 : 8'h00);
    check(op_done == 1'b1, "R10 op_done seen", op_done, 1);
    check(remaining_len == '0, "R10 remaining zero", remaining_len, 0);
    check(digest_count == exp_cnt, "R7 digest count R5 R6", digest_count, exp_cnt);
    check(mode_q == exp_mode, "R5 R6 R8 R9 self clear", mode_q, exp_mode);
    check(n_fetch == exp_fetch, "R2 R8 fetch count", n_fetch, exp_fetch);
    check(n_starts == exp_starts, "R12 pass count", n_starts, exp_starts);
    check(algo_bad == 0, "R1 core_algo", algo_bad, 0);
    idx = 0;
    if (key) begin
      check(kinds[idx] == 2'd1, "R6 key pass first", kinds[idx], 1);
      idx++;
    end
    for (int b = 0; b < blocks; b++) begin
      check(kinds[idx] == 2'd0, "R2 block pass", kinds[idx], 0);
      idx++;
    end
    if (cls) begin
      check(kinds[idx] == 2'd2, "R8 final pass", kinds[idx], 2);
      idx++;
    end
    if (outr) check(kinds[idx] == 2'd3, "R9 outer pass last", kinds[idx], 3);
    @(negedge clk);
    check(!op_done && !busy, "R10 single pulse", {op_done, busy}, 0);
  endtask

  initial begin
    int lens [7] = '{0, 5, 64, 100, 128, 191, 256};
    int op = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !blk_req && !core_start && !op_done && !len_error, "R1 reset outputs",
          {busy, blk_req, core_start, op_done, len_error}, 0);
    check(remaining_len == '0 && digest_count == '0 && mode_q == 8'h00, "R1 reset registers",
          remaining_len | digest_count | DW'(mode_q), 0);
    wr(2'd0, 8'hFF);
    check(mode_q == 8'hBE, "R1 unused mode bits read zero", mode_q, 8'hBE);
    for (int a = 0; a < 4; a++) begin
      for (int f = 0; f < 16; f++) begin
        for (int l = 0; l < 7; l++) begin
          core_lat = 1 + (op % 4);
          ack_lat  = 1 + (op % 3);
          run_op(2'(a), f[3], f[2], f[1], f[0], lens[l], 32'h1234_5600 + DW'(op * 97), 1'b0);
          op++;
        end
      end
    end
    core_lat = 3; ack_lat = 2;
    run_op(2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 256, 32'h0000_1000, 1'b1);
    // sticky error survives a later valid operation
    wr(2'd0, 8'h00);
    wr(2'd1, 32'd10);
    @(negedge clk);
    check(len_error == 1'b1, "R3 error set", len_error, 1);
    wr(2'd1, 32'd64);
    repeat (40) @(negedge clk);
    check(len_error == 1'b1, "R3 error sticky", len_error, 1);
    check(remaining_len == '0 && !busy, "R2 valid op after error", remaining_len, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule